// File: doc/BRIEF.md
# Parallel Display Bus Write Master

This block pushes command and pixel words onto a parallel display bus. It speaks two strobe conventions from one sequencer. In the write-strobe style, every word gets a low pulse on a dedicated write line, and a separate read line stays parked high. In the enable-clocked style, a read/write select line is held at "write" for the whole transaction, and every word gets a high pulse on an enable line. The bus can be 8, 9 or 16 bits wide. The host chooses the style and the width for each request through a 3-bit mode value.

A transaction starts with a single-cycle start request. The request carries the mode, an optional command word and a count of data words. The data words then arrive on a valid/ready stream. The block frames the whole transfer with chip select. It drives the data/command line low for the command and high for the data. It spaces each word by a programmable setup time and a programmable strobe width. A separate request produces an active-high display reset pulse of programmable length. A `busy` flag, a one-cycle `done` pulse and a one-cycle `err` pulse report status.

Top module: `pdw_top`

## Requirements
- R1: `req_mode[2]` selects the style: 0 is write-strobe and 1 is enable-clocked. `req_mode[1:0]` selects the width: 0 is 8 bits, 1 is 9 bits and 2 is 16 bits. A start request whose `req_mode[1:0]` is 3 raises `err` for one cycle in the next cycle, leaves `busy` low and causes no pin activity.
- R2: Chip select (`lcd_cs_n`, active low) falls at request acceptance. It stays low through the command word and every data word. It rises one cycle after the last strobe ends. A request with no command and zero data words holds chip select low for exactly one cycle.
- R3: `lcd_dc` is 0 while the command word is transferred and 1 for every data word.
- R4: In write-strobe mode, each word is on `lcd_bus` for the setup count of cycles with `lcd_wr_n` high. `lcd_wr_n` is then low for the pulse count of cycles. The bus stays unchanged through the rising edge and for one more cycle. `lcd_en` stays low.
- R5: In enable-clocked mode, `lcd_wr_n` acts as the read/write select and is low whenever chip select is low. Each word gets the same setup, then `lcd_en` high for the pulse count, then one hold cycle.
- R6: At idle, the pins are at these levels: `lcd_rd_n`=1, `lcd_wr_n`=1, `lcd_en`=0, `lcd_cs_n`=1, `lcd_dc`=0, `lcd_bus`=0 and `lcd_rst`=0. `lcd_rd_n` is always 1.
- R7: Each word is masked to the selected width. Bits above bit 7 are zero in 8-bit mode, and bits above bit 8 are zero in 9-bit mode.
- R8: A setup count or pulse count of 0 behaves as 1.
- R9: A reset request holds `lcd_rst` high for `cfg_rst_len` cycles, where 0 behaves as 1. It then releases the line and pulses `done`.
- R10: `busy` rises at acceptance and falls in the same cycle that chip select rises or the reset pulse ends. `done` pulses in that cycle. Start and reset requests made while `busy` is high are ignored. If start and reset arrive together at idle, reset wins.
- R11: `s_ready` is high only while the block waits for the next data word. Exactly `req_nwords` stream words are consumed, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start a write transaction (one cycle) |
| req_reset | input | 1 | Start a display reset pulse (one cycle) |
| req_mode | input | 3 | Style and width selection |
| req_has_cmd | input | 1 | Transaction begins with a command word |
| req_cmd | input | 16 | Command word |
| req_nwords | input | CW (16) | Number of data words |
| cfg_setup | input | TW (4) | Setup cycles before the strobe |
| cfg_pulse | input | TW (4) | Strobe active cycles |
| cfg_rst_len | input | RW (16) | Reset pulse length in cycles |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 16 | Stream word |
| s_ready | output | 1 | Stream word accepted when valid |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for an unsupported mode |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_dc | output | 1 | 0 for command, 1 for data |
| lcd_rd_n | output | 1 | Read strobe, parked high |
| lcd_wr_n | output | 1 | Write strobe, or read/write select in enable-clocked mode |
| lcd_en | output | 1 | Enable strobe for enable-clocked mode |
| lcd_bus | output | 16 | Data bus |
| lcd_rst | output | 1 | Display reset, active high |

## Verification
The hardest case to reach from the ports is a request that lands while a transfer or reset pulse is still running. It must be dropped without disturbing the ongoing pulse or starting anything afterwards. The stimulus issues a long reset pulse and fires both a start request and a second reset in its middle. It then measures that the pulse length is unchanged and that chip select stays high afterwards. Stream stalls are also injected between data words, so that chip select must be seen to stay low across gaps where no strobe occurs.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned NARROW = 8;
  localparam int unsigned MID    = 9;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_SETUP, S_STROBE, S_HOLD, S_REL, S_RST
  } seq_t;

  // width code: 0 = 8 bits, 1 = 9 bits, 2 = full width
  function automatic logic [BUS_W-1:0] fit_word(input logic [1:0] wc,
                                                input logic [BUS_W-1:0] w);
    logic [BUS_W-1:0] m;
    m = '1;
    if (wc == 2'd0) m = {{(BUS_W-NARROW){1'b0}}, {NARROW{1'b1}}};
    if (wc == 2'd1) m = {{(BUS_W-MID){1'b0}}, {MID{1'b1}}};
    return w & m;
  endfunction
endpackage

// File: rtl/pdw_rsync.sv
module pdw_rsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pdw_tmr.sv
module pdw_tmr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? val : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pdw_seq.sv
module pdw_seq
  import pdw_pkg::*;
#(
  parameter int unsigned TW = 4,
  parameter int unsigned RW = 16,
  parameter int unsigned CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic             req_reset,
  input  logic [2:0]       req_mode,
  input  logic             req_has_cmd,
  input  logic [BUS_W-1:0] req_cmd,
  input  logic [CW-1:0]    req_nwords,
  input  logic [TW-1:0]    cfg_setup,
  input  logic [TW-1:0]    cfg_pulse,
  input  logic [RW-1:0]    cfg_rst_len,
  input  logic             s_valid,
  input  logic [BUS_W-1:0] s_data,
  output logic             s_ready,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             cs_o,
  output logic             dc_o,
  output logic             strb_o,
  output logic             style_o,
  output logic [BUS_W-1:0] bus_o,
  output logic             rst_o,
  output logic             tmr_load,
  output logic [RW-1:0]    tmr_val,
  input  logic             tmr_zero
);
  seq_t             st_q, st_d;
  logic             cs_q, cs_d, dc_q, dc_d, strb_q, strb_d, rst_q, rst_d;
  logic             style_q, style_d, done_q, done_d, err_q, err_d;
  logic [1:0]       wc_q, wc_d;
  logic [BUS_W-1:0] bus_q, bus_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [RW-1:0]    setup_m1, pulse_m1, rlen_m1;

  always_comb begin
    setup_m1 = (cfg_setup == '0)   ? '0 : RW'(cfg_setup) - RW'(1);
    pulse_m1 = (cfg_pulse == '0)   ? '0 : RW'(cfg_pulse) - RW'(1);
    rlen_m1  = (cfg_rst_len == '0) ? '0 : cfg_rst_len - RW'(1);
  end

  always_comb begin
    st_d = st_q;  cs_d = cs_q;  dc_d = dc_q;  strb_d = strb_q;
    rst_d = rst_q;  style_d = style_q;  wc_d = wc_q;
    bus_d = bus_q;  cnt_d = cnt_q;
    done_d = 1'b0;  err_d = 1'b0;
    tmr_load = 1'b0;  tmr_val = setup_m1;
    unique case (st_q)
      S_IDLE: begin
        if (req_reset) begin
          st_d = S_RST;  rst_d = 1'b1;
          tmr_load = 1'b1;  tmr_val = rlen_m1;
        end else if (req_start) begin
          if (req_mode[1:0] == 2'd3) begin
            err_d = 1'b1;
          end else begin
            style_d = req_mode[2];
            wc_d    = req_mode[1:0];
            cs_d    = 1'b1;
            cnt_d   = req_nwords;
            if (req_has_cmd) begin
              bus_d = fit_word(req_mode[1:0], req_cmd);
              dc_d  = 1'b0;
              st_d  = S_SETUP;
              tmr_load = 1'b1;
            end else begin
              dc_d = 1'b1;
              st_d = (req_nwords == '0) ? S_REL : S_FETCH;
            end
          end
        end
      end
      S_FETCH: begin
        if (s_valid) begin
          bus_d = fit_word(wc_q, s_data);
          cnt_d = cnt_q - CW'(1);
          st_d  = S_SETUP;
          tmr_load = 1'b1;
        end
      end
      S_SETUP: begin
        if (tmr_zero) begin
          strb_d = 1'b1;  st_d = S_STROBE;
          tmr_load = 1'b1;  tmr_val = pulse_m1;
        end
      end
      S_STROBE: begin
        if (tmr_zero) begin
          strb_d = 1'b0;  st_d = S_HOLD;
        end
      end
      S_HOLD: begin
        if (cnt_q != '0) begin
          dc_d = 1'b1;  st_d = S_FETCH;
        end else begin
          cs_d = 1'b0;  dc_d = 1'b0;  bus_d = '0;
          st_d = S_IDLE;  done_d = 1'b1;
        end
      end
      S_REL: begin
        cs_d = 1'b0;  dc_d = 1'b0;  bus_d = '0;
        st_d = S_IDLE;  done_d = 1'b1;
      end
      S_RST: begin
        if (tmr_zero) begin
          rst_d = 1'b0;  st_d = S_IDLE;  done_d = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  cs_q <= 1'b0;  dc_q <= 1'b0;  strb_q <= 1'b0;
      rst_q <= 1'b0;  style_q <= 1'b0;  wc_q <= 2'd0;  bus_q <= '0;
      cnt_q <= '0;  done_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      st_q <= st_d;  cs_q <= cs_d;  dc_q <= dc_d;  strb_q <= strb_d;
      rst_q <= rst_d;  style_q <= style_d;  wc_q <= wc_d;  bus_q <= bus_d;
      cnt_q <= cnt_d;  done_q <= done_d;  err_q <= err_d;
    end
  end

  assign s_ready = (st_q == S_FETCH);
  assign busy    = (st_q != S_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign cs_o    = cs_q;
  assign dc_o    = dc_q;
  assign strb_o  = strb_q;
  assign style_o = style_q;
  assign bus_o   = bus_q;
  assign rst_o   = rst_q;
endmodule

// File: rtl/pdw_pins.sv
module pdw_pins
  import pdw_pkg::*;
(
  input  logic             cs,
  input  logic             dc,
  input  logic             strb,
  input  logic             style,
  input  logic [BUS_W-1:0] bus,
  input  logic             rst,
  output logic             lcd_cs_n,
  output logic             lcd_dc,
  output logic             lcd_rd_n,
  output logic             lcd_wr_n,
  output logic             lcd_en,
  output logic [BUS_W-1:0] lcd_bus,
  output logic             lcd_rst
);
  always_comb begin
    lcd_cs_n = ~cs;
    lcd_dc   = dc;
    lcd_rd_n = 1'b1;
    lcd_wr_n = style ? ~cs : ~strb;   // select line or write strobe
    lcd_en   = style & strb;
    lcd_bus  = bus;
    lcd_rst  = rst;
  end
endmodule

// File: rtl/pdw_top.sv
module pdw_top
  import pdw_pkg::*;
#(
  parameter int unsigned TW = 4,
  parameter int unsigned RW = 16,
  parameter int unsigned CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic             req_reset,
  input  logic [2:0]       req_mode,
  input  logic             req_has_cmd,
  input  logic [BUS_W-1:0] req_cmd,
  input  logic [CW-1:0]    req_nwords,
  input  logic [TW-1:0]    cfg_setup,
  input  logic [TW-1:0]    cfg_pulse,
  input  logic [RW-1:0]    cfg_rst_len,
  input  logic             s_valid,
  input  logic [BUS_W-1:0] s_data,
  output logic             s_ready,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             lcd_cs_n,
  output logic             lcd_dc,
  output logic             lcd_rd_n,
  output logic             lcd_wr_n,
  output logic             lcd_en,
  output logic [BUS_W-1:0] lcd_bus,
  output logic             lcd_rst
);
  logic             srst_n, tmr_load, tmr_zero;
  logic [RW-1:0]    tmr_val;
  logic             cs, dc, strb, style, rst;
  logic [BUS_W-1:0] bus;

  pdw_rsync i_rsync (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  pdw_tmr #(.W(RW)) i_tmr (
    .clk(clk), .rst_n(srst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  pdw_seq #(.TW(TW), .RW(RW), .CW(CW)) i_seq (
    .clk(clk), .rst_n(srst_n),
    .req_start(req_start), .req_reset(req_reset), .req_mode(req_mode),
    .req_has_cmd(req_has_cmd), .req_cmd(req_cmd), .req_nwords(req_nwords),
    .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_rst_len(cfg_rst_len),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .busy(busy), .done(done), .err(err),
    .cs_o(cs), .dc_o(dc), .strb_o(strb), .style_o(style), .bus_o(bus), .rst_o(rst),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_zero(tmr_zero)
  );

  pdw_pins i_pins (
    .cs(cs), .dc(dc), .strb(strb), .style(style), .bus(bus), .rst(rst),
    .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_rd_n(lcd_rd_n),
    .lcd_wr_n(lcd_wr_n), .lcd_en(lcd_en), .lcd_bus(lcd_bus), .lcd_rst(lcd_rst)
  );
endmodule

// File: rtl/pdw_chk.sv
module pdw_chk
  import pdw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             s_ready,
  input logic             err,
  input logic             lcd_cs_n,
  input logic             lcd_dc,
  input logic             lcd_rd_n,
  input logic             lcd_wr_n,
  input logic             lcd_en,
  input logic [BUS_W-1:0] lcd_bus,
  input logic             lcd_rst
);
  a_r6_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lcd_cs_n && lcd_wr_n && !lcd_en && !lcd_dc && lcd_bus == '0 && !lcd_rst));

  a_r6_read_parked: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rd_n);

  a_r2_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en || !lcd_wr_n) |-> !lcd_cs_n);

  a_r5_select_low: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> !lcd_wr_n);

  a_r4_bus_stable_en: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && $past(lcd_en)) |-> ($stable(lcd_bus) && $stable(lcd_dc)));

  a_r1_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (lcd_cs_n && !busy));

  a_r11_ready_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!lcd_cs_n && busy));
endmodule

bind pdw_top pdw_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .s_ready(s_ready), .err(err),
  .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_rd_n(lcd_rd_n),
  .lcd_wr_n(lcd_wr_n), .lcd_en(lcd_en), .lcd_bus(lcd_bus), .lcd_rst(lcd_rst)
);

// File: tb/test_pdw_top.sv
module test_pdw_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0, req_reset = 1'b0, req_has_cmd = 1'b0;
  logic [2:0]  req_mode = 3'd0;
  logic [15:0] req_cmd = '0, req_nwords = '0, cfg_rst_len = '0, s_data = '0;
  logic [3:0]  cfg_setup = 4'd1, cfg_pulse = 4'd1;
  logic        s_valid = 1'b0;
  logic        s_ready, busy, done, err;
  logic        lcd_cs_n, lcd_dc, lcd_rd_n, lcd_wr_n, lcd_en, lcd_rst;
  logic [15:0] lcd_bus;

  always #(CLK_P/2) clk = ~clk;

  pdw_top i_pdw_top (.*);

  int n_chk = 0, n_bad = 0;
  logic [16:0] exp_q[$];
  int  exp_pw = 1;
  bit  tb_style = 1'b0;
  int  last_gap = 0, last_cs_len = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fitw(input logic [2:0] m, input logic [15:0] w);
    if (m[1:0] == 2'd0) return w & 16'h00FF;
    if (m[1:0] == 2'd1) return w & 16'h01FF;
    return w;
  endfunction

  // monitor: decodes strobes on the pins and compares with the scoreboard
  bit prev_strb = 1'b0, prev_cs_n = 1'b1, first = 1'b0;
  int gap = 0, pw = 0, cs_len = 0;
  always @(negedge clk) begin
    bit strb;
    logic [16:0] e;
    strb = tb_style ? lcd_en : !lcd_wr_n;
    if (rst_n) begin
      if (prev_cs_n && !lcd_cs_n) begin gap = 0; first = 1'b1; cs_len = 0; end
      if (!lcd_cs_n) cs_len++;
      if (!lcd_cs_n && first && !strb) gap++;
      if (strb) begin
        if (first) begin last_gap = gap; first = 1'b0; end
        pw++;
      end
      if (prev_strb && !strb) begin
        if (exp_q.size() == 0) chk(1'b0, "R11 unexpected word", int'({lcd_dc, lcd_bus}), 0);
        else begin
          e = exp_q.pop_front();
          chk({lcd_dc, lcd_bus} == e, "R3/R7 word", int'({lcd_dc, lcd_bus}), int'(e));
        end
        chk(pw == exp_pw, "R4 strobe width", pw, exp_pw);
        if (tb_style) chk(lcd_wr_n == 1'b0, "R5 select low", int'(lcd_wr_n), 0);
        else          chk(lcd_en == 1'b0, "R4 enable low", int'(lcd_en), 0);
        chk(lcd_cs_n == 1'b0, "R2 cs held in hold", int'(lcd_cs_n), 0);
        pw = 0;
      end
      if (!prev_cs_n && lcd_cs_n) begin
        last_cs_len = cs_len;
        chk(exp_q.size() == 0, "R2 words missing at cs release", exp_q.size(), 0);
      end
    end
    prev_strb = strb;
    prev_cs_n = lcd_cs_n;
  end

  task automatic xfer(input logic [2:0] m, input bit hc, input logic [15:0] cmd,
                      input int n, input logic [15:0] base, input int su, input int pu,
                      input int stall);
    int su_e;
    su_e = (su == 0) ? 1 : su;
    exp_pw = (pu == 0) ? 1 : pu;
    tb_style = m[2];
    cfg_setup = 4'(su);  cfg_pulse = 4'(pu);
    if (hc) exp_q.push_back({1'b0, fitw(m, cmd)});
    for (int i = 0; i < n; i++) exp_q.push_back({1'b1, fitw(m, base + 16'(i * 16'h1357))});
    req_mode = m;  req_has_cmd = hc;  req_cmd = cmd;  req_nwords = 16'(n);
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
    chk(lcd_cs_n == 1'b0, "R2 cs at accept", int'(lcd_cs_n), 0);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1;  s_data = base + 16'(i * 16'h1357);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0;
      repeat (stall) @(negedge clk);
    end
    while (busy) @(negedge clk);
    chk(done == 1'b1, "R10 done at release", int'(done), 1);
    chk(lcd_cs_n == 1'b1, "R2 cs released with busy", int'(lcd_cs_n), 1);
    @(negedge clk);
    if (hc) chk(last_gap == su_e, "R4/R8 setup cycles", last_gap, su_e);
  endtask

  task automatic rst_pulse(input int len, input bit poke);
    int c = 0, e;
    e = (len == 0) ? 1 : len;
    cfg_rst_len = 16'(len);
    req_reset = 1'b1;
    @(negedge clk);
    req_reset = 1'b0;
    while (busy) begin
      if (lcd_rst) c++;
      if (poke && c == 3) begin
        req_start = 1'b1;  req_reset = 1'b1;  req_mode = 3'd0;  req_nwords = 16'd0;
      end else begin
        req_start = 1'b0;  req_reset = 1'b0;
      end
      @(negedge clk);
    end
    req_start = 1'b0;  req_reset = 1'b0;
    chk(c == e, "R9 reset pulse length", c, e);
    chk(done == 1'b1 && lcd_rst == 1'b0, "R9 done and release", int'({done, lcd_rst}), 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R6 reset state
    chk({lcd_cs_n, lcd_rd_n, lcd_wr_n} == 3'b111, "R6 strobes idle", int'({lcd_cs_n, lcd_rd_n, lcd_wr_n}), 7);
    chk({lcd_en, lcd_dc, lcd_rst, busy, s_ready} == 5'b0, "R6 idle low", int'({lcd_en, lcd_dc, lcd_rst, busy, s_ready}), 0);
    chk(lcd_bus == 16'h0, "R6 bus zero", int'(lcd_bus), 0);

    xfer(3'd0, 1'b1, 16'hF12C, 3, 16'hA5C3, 2, 3, 0);        // R4 8-bit write strobe
    xfer(3'd2, 1'b1, 16'hBEEF, 0, 16'h0, 1, 1, 0);           // R2 command only
    chk(last_cs_len == 3, "R2 cs length command only", last_cs_len, 3);
    xfer(3'd5, 1'b1, 16'hFFFF, 4, 16'h7E81, 3, 2, 2);        // R5 9-bit enable, stalls
    xfer(3'd6, 1'b0, 16'h0, 2, 16'hC0DE, 2, 4, 0);           // R5 16-bit data only
    xfer(3'd1, 1'b1, 16'h03A5, 2, 16'hFE01, 0, 0, 1);        // R8 zero counts
    xfer(3'd4, 1'b1, 16'hABCD, 1, 16'h1FF0, 1, 2, 0);        // R7 8-bit enable mask
    xfer(3'd0, 1'b0, 16'h0, 0, 16'h0, 1, 1, 0);              // R2 empty transaction
    chk(last_cs_len == 1, "R2 empty cs length", last_cs_len, 1);

    // R1 unsupported modes
    for (int k = 0; k < 2; k++) begin
      req_mode = (k == 0) ? 3'd3 : 3'd7;  req_has_cmd = 1'b1;  req_nwords = 16'd2;
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      chk(err == 1'b1 && busy == 1'b0, "R1 err pulse", int'({err, busy}), 2);
      repeat (5) begin
        @(negedge clk);
        chk(lcd_cs_n == 1'b1 && err == 1'b0, "R1 no bus activity", int'({lcd_cs_n, err}), 2);
      end
    end

    rst_pulse(5, 1'b0);                                       // R9
    rst_pulse(0, 1'b0);                                       // R9 zero length
    rst_pulse(20, 1'b1);                                      // R10 requests while busy
    repeat (8) begin
      @(negedge clk);
      chk(lcd_cs_n == 1'b1 && lcd_rst == 1'b0 && busy == 1'b0, "R10 ignored request",
          int'({lcd_cs_n, lcd_rst, busy}), 4);
    end
    // R10 simultaneous start and reset: reset wins
    exp_q.delete();
    req_mode = 3'd0;  req_has_cmd = 1'b1;  cfg_rst_len = 16'd2;
    req_start = 1'b1;  req_reset = 1'b1;
    @(negedge clk);
    req_start = 1'b0;  req_reset = 1'b0;
    chk(lcd_rst == 1'b1 && lcd_cs_n == 1'b1, "R10 reset priority", int'({lcd_rst, lcd_cs_n}), 3);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule